// File: doc/BRIEF.md
# Test Vector Force/Compare Engine

This block replays a stored table of test vectors against a bank of device pins, one vector per tester cycle. Every stored vector holds one data bit per channel and the number of a template. The template gives every channel a role for that cycle: it is driven with the vector's bit, its captured pin value is compared with the vector's bit, or it is ignored. Because the role comes from the template that each vector names, a bidirectional pin can be driven on one cycle and checked on the next.

An outside timing generator supplies two pulses: the tester cycle boundary, which moves the engine to the next vector, and the compare strobe, which samples the pins within the cycle. Each strobe yields a per-channel mismatch word tagged with the vector index. A sticky fail flag and the index of the first failing vector summarise a run. Vectors and templates are loaded beforehand through two plain write ports.

Channels are grouped into sectors of equal size (16 sectors of 16 channels by default). Channel number c = sector * CH_PER_SEC + lane.

Top module: `tvfc_engine`

## Requirements
- R1: Template word bits [2c+1:2c] give the role of channel c: 2'b01 drive, 2'b10 compare, 2'b00 and 2'b11 mask; a vector's template number is written with it on `vec_wtpl`.
- R2: On the clock edge where `tcyc` applies a vector, every drive channel of its template gets `drv_oe` = 1 and `drv_val` = the vector's bit for that channel, visible after that edge.
- R3: A compare or masked channel has `drv_oe` = 0 and `drv_val` = 0, and no channel ever shows a mismatch while it is driven.
- R4: A masked channel reports mismatch 0 whatever value its pin carries.
- R5: On a `strobe` edge while a vector is applied, `mism` registers (pin XOR vector bit) for each compare channel, `mism_valid` pulses for one cycle and `mism_idx` carries that vector's index.
- R6: After a `start` pulse, the first `tcyc` at least 3 clocks later applies vector 0, and each later `tcyc` applies the next index; `tcyc` pulses must be at least 3 clocks apart.
- R7: The `tcyc` that follows the vector at index `last_idx` (sampled at start) ends the run: `done` pulses for one cycle, `busy` falls and all `drv_oe` bits go to 0 on that edge.
- R8: The first strobe with any mismatch sets `fail` and latches its vector index in `first_fail_idx`; both hold until the next accepted `start`, which clears them.
- R9: A `start` pulse while `busy` is ignored: the run continues with the next vector and `fail` is unchanged.
- R10: The vector store holds 2^AW entries (AW = 16 gives 64K vectors) and the template store TPL_N entries, each loaded through its own write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_we | input | 1 | Vector store write enable |
| vec_waddr | input | AW | Vector store write index |
| vec_wdata | input | N | Vector data bits, one per channel |
| vec_wtpl | input | TW | Template number of the vector |
| tpl_we | input | 1 | Template store write enable |
| tpl_waddr | input | TW | Template number to write |
| tpl_wrole | input | 2*N | Two role bits per channel |
| start | input | 1 | Begin a run at vector 0 |
| last_idx | input | AW | Index of the final vector of the run |
| tcyc | input | 1 | Tester cycle boundary pulse |
| strobe | input | 1 | Compare sampling pulse |
| dut_in | input | N | Captured pin values |
| drv_val | output | N | Values driven onto the pins |
| drv_oe | output | N | Per-channel drive enable |
| mism | output | N | Per-channel mismatch of the last strobe |
| mism_valid | output | 1 | One-cycle pulse: `mism` updated |
| mism_idx | output | AW | Vector index belonging to `mism` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Sticky: a mismatch was seen in this run |
| first_fail_idx | output | AW | Vector index of the first mismatch |

## Verification
Every cycle, the assertions check that a channel never carries a mismatch while driven, that no pin is driven outside a run, that a reported mismatch always comes with the fail flag, that the fail flag and the first failing index stay put until a new run, and that the end pulse is single and leaves the engine idle. Only the bench's scenarios can show the data path itself: that each vector's template selects the right drive, compare and mask channels, that the vector order and the run length follow the start and last index, that masked pins with wrong values stay silent, and that a start during a run is ignored.

// File: rtl/tvfc_pkg.sv
package tvfc_pkg;

  // Two-bit role of one channel inside a template word.
  typedef enum logic [1:0] {
    ROLE_OFF   = 2'b00,
    ROLE_DRIVE = 2'b01,
    ROLE_CHECK = 2'b10,
    ROLE_OFF2  = 2'b11
  } role_e;

endpackage

// File: rtl/tvfc_ram.sv
// Simple dual-port storage, registered read, written for block RAM inference.
module tvfc_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tvfc_seq.sv
// Run sequencer: walks the vector index, paces prefetch, ends the run.
module tvfc_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] last_idx,
  input  logic          tcyc,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] cur_idx,
  output logic          cur_v,
  output logic          apply,
  output logic          finish,
  output logic          start_ok,
  output logic          busy,
  output logic          done
);
  // Two clocks of read latency: vector store, then template store.
  localparam logic [1:0] FETCH_LAT = 2'd2;

  logic [1:0]    wait_q;
  logic [AW-1:0] last_q;
  logic          run_q;

  assign start_ok = start && !run_q;
  assign finish   = tcyc && cur_v && (cur_idx == last_q);
  assign apply    = tcyc && run_q && (wait_q == 2'd0) && !finish;
  assign busy     = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q  <= '0;
      last_q  <= '0;
      run_q   <= 1'b0;
      rd_addr <= '0;
      cur_idx <= '0;
      cur_v   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        run_q   <= 1'b1;
        rd_addr <= '0;
        wait_q  <= FETCH_LAT;
        cur_v   <= 1'b0;
        last_q  <= last_idx;
      end else if (finish) begin
        run_q <= 1'b0;
        cur_v <= 1'b0;
        done  <= 1'b1;
      end else if (apply) begin
        cur_idx <= rd_addr;
        cur_v   <= 1'b1;
        rd_addr <= rd_addr + 1'b1;
        wait_q  <= FETCH_LAT;
      end else if (wait_q != 2'd0) begin
        wait_q <= wait_q - 2'd1;
      end
    end
  end
endmodule

// File: rtl/tvfc_sector.sv
// One sector of channels: role decode, drive registers, compare at strobe.
module tvfc_sector
  import tvfc_pkg::*;
#(
  parameter int CH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            apply,
  input  logic            finish,
  input  logic            strobe_ok,
  input  logic [2*CH-1:0] role,
  input  logic [CH-1:0]   data,
  input  logic [CH-1:0]   pins,
  output logic [CH-1:0]   drv_val,
  output logic [CH-1:0]   drv_oe,
  output logic [CH-1:0]   mism,
  output logic [CH-1:0]   hit
);
  logic [CH-1:0] drv_bits;
  logic [CH-1:0] chk_bits;
  logic [CH-1:0] exp_q;
  logic [CH-1:0] chk_q;

  for (genvar c = 0; c < CH; c++) begin : g_lane
    assign drv_bits[c] = (role_e'(role[2*c +: 2]) == ROLE_DRIVE);
    assign chk_bits[c] = (role_e'(role[2*c +: 2]) == ROLE_CHECK);
  end

  assign hit = (pins ^ exp_q) & chk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_val <= '0;
      drv_oe  <= '0;
      exp_q   <= '0;
      chk_q   <= '0;
      mism    <= '0;
    end else begin
      if (finish) begin
        drv_val <= '0;
        drv_oe  <= '0;
        chk_q   <= '0;
      end else if (apply) begin
        drv_val <= data & drv_bits;
        drv_oe  <= drv_bits;
        exp_q   <= data;
        chk_q   <= chk_bits;
      end
      if (strobe_ok) mism <= hit;
    end
  end
endmodule

// File: rtl/tvfc_engine.sv
module tvfc_engine #(
  parameter int SECTORS    = 16,
  parameter int CH_PER_SEC = 16,
  parameter int AW         = 8,
  parameter int TPL_N      = 4,
  localparam int N         = SECTORS * CH_PER_SEC,
  localparam int TW        = (TPL_N > 1) ? $clog2(TPL_N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vec_we,
  input  logic [AW-1:0]   vec_waddr,
  input  logic [N-1:0]    vec_wdata,
  input  logic [TW-1:0]   vec_wtpl,
  input  logic            tpl_we,
  input  logic [TW-1:0]   tpl_waddr,
  input  logic [2*N-1:0]  tpl_wrole,
  input  logic            start,
  input  logic [AW-1:0]   last_idx,
  input  logic            tcyc,
  input  logic            strobe,
  input  logic [N-1:0]    dut_in,
  output logic [N-1:0]    drv_val,
  output logic [N-1:0]    drv_oe,
  output logic [N-1:0]    mism,
  output logic            mism_valid,
  output logic [AW-1:0]   mism_idx,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [AW-1:0]   first_fail_idx
);
  localparam int VW = N + TW;

  logic [AW-1:0]  rd_addr;
  logic [AW-1:0]  cur_idx;
  logic           cur_v;
  logic           apply;
  logic           finish;
  logic           start_ok;
  logic           strobe_ok;
  logic [VW-1:0]  vec_q;
  logic [2*N-1:0] tpl_q;
  logic [N-1:0]   data_d;
  logic [N-1:0]   hit;

  tvfc_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .last_idx (last_idx),
    .tcyc     (tcyc),
    .rd_addr  (rd_addr),
    .cur_idx  (cur_idx),
    .cur_v    (cur_v),
    .apply    (apply),
    .finish   (finish),
    .start_ok (start_ok),
    .busy     (busy),
    .done     (done)
  );

  tvfc_ram #(.AW(AW), .DW(VW)) u_vec_ram (
    .clk   (clk),
    .we    (vec_we),
    .waddr (vec_waddr),
    .wdata ({vec_wtpl, vec_wdata}),
    .raddr (rd_addr),
    .rdata (vec_q)
  );

  tvfc_ram #(.AW(TW), .DW(2*N)) u_tpl_ram (
    .clk   (clk),
    .we    (tpl_we),
    .waddr (tpl_waddr),
    .wdata (tpl_wrole),
    .raddr (vec_q[VW-1 -: TW]),
    .rdata (tpl_q)
  );

  // Align vector data with the template read one clock later.
  always_ff @(posedge clk) begin
    if (rst) data_d <= '0;
    else     data_d <= vec_q[N-1:0];
  end

  assign strobe_ok = strobe && cur_v;

  for (genvar s = 0; s < SECTORS; s++) begin : g_sector
    tvfc_sector #(.CH(CH_PER_SEC)) u_sector (
      .clk       (clk),
      .rst       (rst),
      .apply     (apply),
      .finish    (finish),
      .strobe_ok (strobe_ok),
      .role      (tpl_q[2*CH_PER_SEC*s +: 2*CH_PER_SEC]),
      .data      (data_d[CH_PER_SEC*s +: CH_PER_SEC]),
      .pins      (dut_in[CH_PER_SEC*s +: CH_PER_SEC]),
      .drv_val   (drv_val[CH_PER_SEC*s +: CH_PER_SEC]),
      .drv_oe    (drv_oe[CH_PER_SEC*s +: CH_PER_SEC]),
      .mism      (mism[CH_PER_SEC*s +: CH_PER_SEC]),
      .hit       (hit[CH_PER_SEC*s +: CH_PER_SEC])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mism_valid     <= 1'b0;
      mism_idx       <= '0;
      fail           <= 1'b0;
      first_fail_idx <= '0;
    end else begin
      mism_valid <= strobe_ok;
      if (strobe_ok) mism_idx <= cur_idx;
      if (start_ok) begin
        fail           <= 1'b0;
        first_fail_idx <= '0;
      end else if (strobe_ok && (|hit) && !fail) begin
        fail           <= 1'b1;
        first_fail_idx <= cur_idx;
      end
    end
  end
endmodule

// File: rtl/tvfc_engine_chk.sv
module tvfc_engine_chk #(
  parameter int N  = 256,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          tcyc,
  input logic          strobe,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          mism_valid,
  input logic [N-1:0]  mism,
  input logic [N-1:0]  drv_oe,
  input logic [AW-1:0] first_fail_idx
);
  AST_NO_DRIVEN_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    (strobe && !tcyc) |=> (!mism_valid || ((mism & drv_oe) == '0))); // R3

  AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (drv_oe == '0)); // R7

  AST_MISMATCH_FLAGS_FAIL: assert property (@(posedge clk) disable iff (rst)
    (mism_valid && (mism != '0)) |-> fail); // R8

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> fail); // R8

  AST_FIRST_FAIL_HELD: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> $stable(first_fail_idx)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !tcyc) |=> busy); // R9
endmodule

bind tvfc_engine tvfc_engine_chk #(.N(N), .AW(AW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .start          (start),
  .tcyc           (tcyc),
  .strobe         (strobe),
  .busy           (busy),
  .done           (done),
  .fail           (fail),
  .mism_valid     (mism_valid),
  .mism           (mism),
  .drv_oe         (drv_oe),
  .first_fail_idx (first_fail_idx)
);

// File: tb/tb_tvfc_engine.sv
`timescale 1ns/1ps
module tb_tvfc_engine;
  localparam int N  = 256;
  localparam int AW = 8;
  localparam int TW = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           vec_we = 1'b0;
  logic [AW-1:0]  vec_waddr = '0;
  logic [N-1:0]   vec_wdata = '0;
  logic [TW-1:0]  vec_wtpl = '0;
  logic           tpl_we = 1'b0;
  logic [TW-1:0]  tpl_waddr = '0;
  logic [2*N-1:0] tpl_wrole = '0;
  logic           start = 1'b0;
  logic [AW-1:0]  last_idx = '0;
  logic           tcyc = 1'b0;
  logic           strobe = 1'b0;
  logic [N-1:0]   dut_in = '0;
  logic [N-1:0]   drv_val, drv_oe, mism;
  logic           mism_valid, busy, done, fail;
  logic [AW-1:0]  mism_idx, first_fail_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [N-1:0] exp_mism_q[$];
  int           exp_idx_q[$];

  always #5 clk = ~clk;

  tvfc_engine dut (
    .clk(clk), .rst(rst), .vec_we(vec_we), .vec_waddr(vec_waddr),
    .vec_wdata(vec_wdata), .vec_wtpl(vec_wtpl), .tpl_we(tpl_we),
    .tpl_waddr(tpl_waddr), .tpl_wrole(tpl_wrole), .start(start),
    .last_idx(last_idx), .tcyc(tcyc), .strobe(strobe), .dut_in(dut_in),
    .drv_val(drv_val), .drv_oe(drv_oe), .mism(mism), .mism_valid(mism_valid),
    .mism_idx(mism_idx), .busy(busy), .done(done), .fail(fail),
    .first_fail_idx(first_fail_idx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Role codes (R1): 1 drive, 2 compare, 0/3 mask.
  function automatic logic [1:0] role_of(input int t, input int c);
    case (t)
      0: role_of = (c % 3 == 0) ? 2'b01 : ((c % 3 == 1) ? 2'b10 : 2'b00);
      1: role_of = 2'b10;
      2: role_of = 2'b01;
      default: role_of = (c % 2 == 1) ? 2'b11 : 2'b00;
    endcase
  endfunction

  function automatic logic [N-1:0] vdata(input int v);
    logic [N-1:0] d;
    for (int i = 0; i < N / 32; i++)
      d[32*i +: 32] = (32'(v) * 32'h9E3779B1) ^ (32'(i) * 32'h01010101) ^ 32'h5A5A0000;
    return d;
  endfunction

  // Scoreboard monitor (R5, R6).
  always @(negedge clk) begin
    if (!rst && mism_valid) begin
      if (exp_mism_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected mismatch report", mism, '0);
      end else begin
        logic [N-1:0] em;
        int ei;
        em = exp_mism_q.pop_front();
        ei = exp_idx_q.pop_front();
        chk(mism == em, "R4,R5", "mismatch word", mism, em);
        chk(int'(mism_idx) == ei, "R6", "vector order", N'(mism_idx), N'(ei));
      end
    end
  end

  task automatic tester_cycle(input int v, input logic [N-1:0] err);
    logic [N-1:0] d, e_oe, e_val, cmpm, pin;
    logic [1:0] r;
    d = vdata(v);
    for (int c = 0; c < N; c++) begin
      r = role_of(v % 4, c);
      e_oe[c]  = (r == 2'b01);
      e_val[c] = (r == 2'b01) ? d[c] : 1'b0;
      cmpm[c]  = (r == 2'b10);
    end
    @(negedge clk) tcyc = 1'b1;
    @(negedge clk) tcyc = 1'b0;
    chk(drv_oe == e_oe, "R1,R2", "drive enable", drv_oe, e_oe);
    chk(drv_val == e_val, "R2,R3", "drive value", drv_val, e_val);
    // Pins not compared carry the wrong value on purpose (R4).
    pin = (cmpm & (d ^ err)) | (~cmpm & ~d);
    dut_in = pin;
    strobe = 1'b1;
    exp_mism_q.push_back(err & cmpm);
    exp_idx_q.push_back(v);
    @(negedge clk) strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_run(input int last);
    @(negedge clk);
    start = 1'b1;
    last_idx = AW'(last);
    @(negedge clk) start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic end_run;
    @(negedge clk) tcyc = 1'b1;
    @(negedge clk) tcyc = 1'b0;
    chk(done == 1'b1, "R7", "done pulse", N'(done), N'(1));
    chk(busy == 1'b0, "R7", "busy after end", N'(busy), N'(0));
    chk(drv_oe == '0, "R7", "drive released", drv_oe, '0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done single cycle", N'(done), N'(0));
  endtask

  function automatic logic [N-1:0] bit_at(input int c);
    logic [N-1:0] b = '0;
    b[c] = 1'b1;
    return b;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(drv_oe == '0, "R7", "reset drive", drv_oe, '0);
    chk({busy, done, fail} == 3'b000, "R8", "reset flags", N'({busy, done, fail}), '0);

    // R10: load templates and vectors through the write ports.
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      tpl_we = 1'b1;
      tpl_waddr = TW'(t);
      for (int c = 0; c < N; c++) tpl_wrole[2*c +: 2] = role_of(t, c);
    end
    for (int v = 0; v < 12; v++) begin
      @(negedge clk);
      tpl_we = 1'b0;
      vec_we = 1'b1;
      vec_waddr = AW'(v);
      vec_wdata = vdata(v);
      vec_wtpl = TW'(v % 4);
    end
    @(negedge clk) vec_we = 1'b0;

    // Run 1: clean pass over vectors 0..5.
    start_run(5);
    chk(busy == 1'b1, "R6", "busy after start", N'(busy), N'(1));
    for (int v = 0; v <= 5; v++) tester_cycle(v, '0);
    end_run();
    chk(fail == 1'b0, "R8", "clean run fail flag", N'(fail), '0);

    // Run 2: errors on compare and masked channels, first fail at 5.
    start_run(9);
    for (int v = 0; v <= 9; v++) begin
      logic [N-1:0] err;
      err = '0;
      if (v == 3) err = bit_at(4);                 // all masked template
      if (v == 4) err = bit_at(2);                 // masked lane in template 0
      if (v == 5) err = bit_at(1) | bit_at(200);   // all compare template
      if (v == 6) err = bit_at(4);                 // all drive template
      if (v == 9) err = bit_at(7);
      tester_cycle(v, err);
      if (v == 5) begin
        chk(fail == 1'b1, "R8", "fail set", N'(fail), N'(1));
        chk(first_fail_idx == AW'(5), "R8", "first fail index", N'(first_fail_idx), N'(5));
      end
      if (v == 6) begin
        // R9: start while busy is ignored.
        @(negedge clk) start = 1'b1;
        last_idx = AW'(0);
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R9", "busy kept", N'(busy), N'(1));
        chk(fail == 1'b1, "R9", "fail kept", N'(fail), N'(1));
      end
    end
    end_run();
    chk(first_fail_idx == AW'(5), "R8", "first fail held", N'(first_fail_idx), N'(5));

    // Run 3: new start clears fail; single-vector run.
    start_run(0);
    chk(fail == 1'b0, "R8", "fail cleared by start", N'(fail), '0);
    tester_cycle(0, bit_at(1));
    chk(fail == 1'b1, "R8", "fail on vector 0", N'(fail), N'(1));
    chk(first_fail_idx == '0, "R8", "first fail zero", N'(first_fail_idx), '0);
    end_run();

    repeat (2) @(negedge clk);
    chk(exp_mism_q.size() == 0, "R5", "all strobes reported", N'(exp_mism_q.size()), '0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule